// File: doc/BRIEF.md
# Serial-Scan Wrapper for a Synchronous Dual-Port Memory

This block puts a small memory whose reads and writes are both clocked, and whose read data sits in an output register, into a one-bit serial scan chain. In normal operation a user write port and a user read port reach the memory, and read data shows up on `rd_data` one cycle after a read is issued. While `scan_en` is high the user ports are shut out. The memory state then leaves through `scan_out` one bit per cycle, and new state arrives on `scan_in` at the same rate.

The serial stream begins with the word held by the output register. The memory words follow in ascending address order, and each word is sent least significant bit first. A full image is therefore `DW*(DEPTH+1)` bits long. That register cannot be refilled from outside. For this reason a shadow register keeps its value at scan entry, or keeps the value loaded through scan, and it supplies `rd_data` after scan until the next user read.

A read-side shifter and a write-side shifter convert between words and bits. During scan the memory read port fetches the next word while the write port stores the word that has just been assembled. `scan_mode` picks between load, where incoming bits replace the image, and unload, where the image is only observed and circulates without change.

Top module: `bram_scan_wrap`

## Requirements
- R1: After reset, `rd_data` is 0 and `scan_out` is 0.
- R2: With `scan_en` low, `wr_en` writes `wr_data` at `wr_addr`. When `rd_en` is high, `rd_data` shows the word at `rd_addr` from the next cycle on.
- R3: In scan cycle k, counted from 0 at the first cycle with `scan_en` high, `scan_out` presents bit k of the image. Bits 0..DW-1 are the visible `rd_data` word. Bits DW*(a+1)..DW*(a+2)-1 are the word at address a, least significant bit first.
- R4: In load mode (`scan_mode`=1), a scan of exactly DW*(DEPTH+1) cycles (or a whole multiple of that) leaves image bit k equal to `scan_in` from cycle n-L+k. Here n is the scan length and L = DW*(DEPTH+1).
- R5: In load mode the scan behaves as an L-bit FIFO: `scan_out` in cycle L+k equals `scan_in` from cycle k.
- R6: In unload mode (`scan_mode`=0), `scan_in` has no effect. Memory and `rd_data` come out of a scan of any length unchanged, and the stream repeats with period L.
- R7: No memory write happens during the first DW scan cycles. After that, scan writes occur only in the last cycle of a word period, at an address one below the address read in the same cycle.
- R8: During an unload scan `rd_data` holds the value it had at scan entry. After any scan, `rd_data` shows image bits 0..DW-1 until the next user read.
- R9: `wr_en`, `rd_en` and their address and data inputs are ignored while `scan_en` is high.
- R10: A load-mode scan shorter than DW cycles changes neither the memory nor `rd_data`.
- R11: `scan_out` is 0 whenever `scan_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | User write enable |
| wr_addr | input | AW | User write address |
| wr_data | input | DW | User write data |
| rd_en | input | 1 | User read enable |
| rd_addr | input | AW | User read address |
| rd_data | output | DW | Visible output-register word |
| scan_en | input | 1 | Scan shifting when high |
| scan_mode | input | 1 | 1 = load, 0 = unload (observe) |
| scan_in | input | 1 | Serial state in |
| scan_out | output | 1 | Serial state out |

## Verification
The memory is filled with a pattern that differs per address, so any word-order or bit-order slip in the unload stream shows up as a mismatch. Unload runs longer than one image, and ending mid-word, separate a circulating, non-destructive chain from one that shifts in `scan_in`. During these runs the user ports are toggled to expose any leak past the scan gate. A load run of exactly one image checks that the state is replaced. A run of two images separates a true FIFO from an image that comes out rotated. A load run shorter than one word shows whether the early write inhibit and the shadow restore hold.

// File: rtl/scan_wrap_pkg.sv
`timescale 1ns/1ps
package scan_wrap_pkg;
  typedef enum logic {
    SCAN_UNLOAD = 1'b0,
    SCAN_LOAD   = 1'b1
  } scan_mode_e;

  // Serial image length: one output-register word plus every memory word.
  function automatic int unsigned image_bits(int unsigned dw, int unsigned depth);
    return dw * (depth + 1);
  endfunction
endpackage

// File: rtl/scan_seq.sv
`timescale 1ns/1ps
// Tracks the bit position inside a word and the word slot inside the image.
// Slot 0 is the output register; slot s>0 is memory address s-1.
module scan_seq #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int BW   = (DW > 1) ? $clog2(DW) : 1,
  localparam int SW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scan_en,
  output logic          first,
  output logic          word_end,
  output logic          bit_first,
  output logic          slot_zero,
  output logic          slot_last,
  output logic [SW-1:0] slot
);
  logic          scan_q;
  logic [BW-1:0] bcnt;

  assign first     = scan_en && !scan_q;
  assign word_end  = scan_en && (bcnt == BW'(DW - 1));
  assign bit_first = (bcnt == '0);
  assign slot_zero = (slot == '0);
  assign slot_last = (slot == SW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_q <= 1'b0;
      bcnt   <= '0;
      slot   <= '0;
    end else begin
      scan_q <= scan_en;
      if (!scan_en) begin
        bcnt <= '0;
        slot <= '0;
      end else if (word_end) begin
        bcnt <= '0;
        slot <= slot_last ? '0 : slot + SW'(1);
      end else begin
        bcnt <= bcnt + BW'(1);
      end
    end
  end
endmodule

// File: rtl/scan_serdes.sv
`timescale 1ns/1ps
// Word-to-bit on the outgoing side, bit-to-word on the incoming side.
module scan_serdes #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scan_en,
  input  logic          bit_first,
  input  logic [DW-1:0] head_word,
  input  logic          scan_in,
  output logic          scan_out,
  output logic [DW-1:0] in_word
);
  logic [DW-1:0] piso;
  logic [DW-1:0] sipo;

  // New bit enters at the top, so the first bit of a word ends at bit 0.
  function automatic logic [DW-1:0] push_top(logic [DW-1:0] w, logic b);
    logic [DW-1:0] t;
    t         = w >> 1;
    t[DW-1]   = b;
    return t;
  endfunction

  assign in_word  = push_top(sipo, scan_in);
  assign scan_out = scan_en && (bit_first ? head_word[0] : piso[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      piso <= '0;
      sipo <= '0;
    end else if (scan_en) begin
      sipo <= in_word;
      piso <= bit_first ? (head_word >> 1) : (piso >> 1);
    end
  end
endmodule

// File: rtl/scan_ram.sv
`timescale 1ns/1ps
// Two-port memory, clocked write and clocked read into an output register.
module scan_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (re) q <= mem[ra];
  end
endmodule

// File: rtl/bram_scan_wrap.sv
`timescale 1ns/1ps
module bram_scan_wrap
  import scan_wrap_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int SW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          scan_en,
  input  logic          scan_mode,
  input  logic          scan_in,
  output logic          scan_out
);
  // Sequencer events, named for the checker.
  logic          first, word_end, bit_first, slot_zero, slot_last;
  logic [SW-1:0] slot;
  // Memory port signals after the scan/user multiplexers.
  logic          ram_we, ram_re;
  logic [AW-1:0] ram_wa, ram_ra;
  logic [DW-1:0] ram_wd, ram_q;
  // Serial path.
  logic [DW-1:0] in_word, head_word;
  // Output-register preservation.
  logic [DW-1:0] shadow;
  logic          use_shadow;
  logic          load;
  scan_mode_e    mode;

  function automatic logic [AW-1:0] slot_rd_addr(logic [SW-1:0] s);
    return AW'(s);
  endfunction

  function automatic logic [AW-1:0] slot_wr_addr(logic [SW-1:0] s);
    return AW'(s - SW'(1));
  endfunction

  assign mode = scan_mode_e'(scan_mode);
  assign load = (mode == SCAN_LOAD);

  scan_seq #(.DW(DW), .DEPTH(DEPTH)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .scan_en  (scan_en),
    .first    (first),
    .word_end (word_end),
    .bit_first(bit_first),
    .slot_zero(slot_zero),
    .slot_last(slot_last),
    .slot     (slot)
  );

  // Scan write stores the word just assembled (slot s -> address s-1) while
  // the read fetches address s, so the write trails the read by one word.
  assign ram_we = scan_en ? (word_end && load && !slot_zero) : wr_en;
  assign ram_wa = scan_en ? slot_wr_addr(slot) : wr_addr;
  assign ram_wd = scan_en ? in_word : wr_data;
  assign ram_re = scan_en ? (word_end && !slot_last) : rd_en;
  assign ram_ra = scan_en ? slot_rd_addr(slot) : rd_addr;

  scan_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (ram_we),
    .wa   (ram_wa),
    .wd   (ram_wd),
    .re   (ram_re),
    .ra   (ram_ra),
    .q    (ram_q)
  );

  assign rd_data   = use_shadow ? shadow : ram_q;
  assign head_word = slot_zero ? rd_data : ram_q;

  scan_serdes #(.DW(DW)) u_serdes (
    .clk      (clk),
    .rst_n    (rst_n),
    .scan_en  (scan_en),
    .bit_first(bit_first),
    .head_word(head_word),
    .scan_in  (scan_in),
    .scan_out (scan_out),
    .in_word  (in_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow     <= '0;
      use_shadow <= 1'b0;
    end else begin
      if (word_end && load && slot_zero) shadow <= in_word;
      else if (first)                    shadow <= rd_data;
      if (scan_en)    use_shadow <= 1'b1;
      else if (rd_en) use_shadow <= 1'b0;
    end
  end
endmodule

// File: rtl/bram_scan_wrap_chk.sv
`timescale 1ns/1ps
module bram_scan_wrap_chk #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DW + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scan_en,
  input logic          scan_mode,
  input logic          scan_out,
  input logic [DW-1:0] rd_data,
  input logic          ram_we,
  input logic          ram_re,
  input logic [AW-1:0] ram_wa,
  input logic [AW-1:0] ram_ra
);
  // Independent counters: cycles into the scan (saturating) and bit phase.
  logic [CW-1:0] win;
  logic [CW-1:0] ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win <= '0;
      ph  <= '0;
    end else if (!scan_en) begin
      win <= '0;
      ph  <= '0;
    end else begin
      if (win != CW'(DW)) win <= win + CW'(1);
      ph <= (ph == CW'(DW - 1)) ? '0 : ph + CW'(1);
    end
  end

  a_r7_first_word_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && win < CW'(DW)) |-> !ram_we);

  a_r7_write_on_word_end: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && ram_we) |-> (ph == CW'(DW - 1)));

  a_r7_write_trails_read: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && ram_we && ram_re) |-> (ram_ra == ram_wa + AW'(1)));

  a_r6_unload_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && !scan_mode) |-> !ram_we);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |-> !scan_out);

  a_r8_unload_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && $past(scan_en) && !scan_mode && !$past(scan_mode)) |-> $stable(rd_data));
endmodule

bind bram_scan_wrap bram_scan_wrap_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scan_en  (scan_en),
  .scan_mode(scan_mode),
  .scan_out (scan_out),
  .rd_data  (rd_data),
  .ram_we   (ram_we),
  .ram_re   (ram_re),
  .ram_wa   (ram_wa),
  .ram_ra   (ram_ra)
);

// File: tb/tb_bram_scan_wrap.sv
`timescale 1ns/1ps
module tb_bram_scan_wrap;
  localparam int DW    = 8;
  localparam int DEPTH = 8;
  localparam int AW    = $clog2(DEPTH);
  localparam int L     = DW * (DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          scan_en = 1'b0, scan_mode = 1'b0, scan_in = 1'b0;
  logic          scan_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [DW-1:0] exp_mem [DEPTH];
  logic [DW-1:0] exp_out;
  logic          sb_bit [$];
  string         sb_tag [$];

  always #2.5 clk = ~clk;

  bram_scan_wrap #(.DW(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .scan_en(scan_en), .scan_mode(scan_mode), .scan_in(scan_in), .scan_out(scan_out)
  );

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic gen_bit(int seed, int k);
    logic [31:0] v;
    v = 32'(k * 7 + seed * 13 + (k >> 3) * 5);
    return v[0] ^ v[2];
  endfunction

  function automatic logic img_bit(int k);
    if (k < DW) return exp_out[k % DW];
    return exp_mem[k / DW - 1][k % DW];
  endfunction

  // Monitor: compares the serial output against the scoreboard.
  always begin
    @(negedge clk);
    #1;
    if (scan_en && sb_bit.size() > 0) begin
      logic  e;
      string t;
      e = sb_bit.pop_front();
      t = sb_tag.pop_front();
      check(32'(scan_out), 32'(e), t);
    end
  end

  task automatic write_word(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    exp_mem[a] = d;
  endtask

  task automatic read_word(logic [AW-1:0] a, string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    #1;
    check(32'(rd_data), 32'(exp_mem[a]), tag);
    exp_out = exp_mem[a];
  endtask

  task automatic read_all(string tag);
    for (int a = 0; a < DEPTH; a++) read_word(AW'(a), tag);
  endtask

  // Driver: runs n scan cycles and pushes the expected serial bits.
  task automatic scan_run(bit load, int n, int seed, bit poke, string tag);
    logic [DW-1:0] o0;
    o0 = exp_out;
    for (int k = 0; k < n; k++) begin
      logic e;
      @(negedge clk);
      scan_en = 1'b1; scan_mode = load; scan_in = gen_bit(seed, k);
      if (poke) begin
        wr_en = 1'b1; wr_addr = AW'(k); wr_data = ~DW'(k); rd_en = 1'b1; rd_addr = AW'(k + 1);
      end
      if (k < L)     e = img_bit(k);
      else if (load) e = gen_bit(seed, k - L);
      else           e = img_bit(k % L);
      sb_bit.push_back(e);
      sb_tag.push_back(tag);
      if (!load && k == L / 2) begin
        #1;
        check(32'(rd_data), 32'(o0), "R8 rd_data frozen during unload scan");
      end
    end
    @(negedge clk);
    scan_en = 1'b0; scan_in = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    #1;
    if (load && n >= L && n % L == 0) begin
      for (int k = 0; k < DW; k++) exp_out[k] = gen_bit(seed, n - L + k);
      for (int a = 0; a < DEPTH; a++)
        for (int b = 0; b < DW; b++) exp_mem[a][b] = gen_bit(seed, n - L + DW * (a + 1) + b);
    end
    check(32'(scan_out), 32'd0, "R11 scan_out low when idle");
    check(32'(sb_bit.size()), 32'd0, "R3 all scan bits observed");
    check(32'(rd_data), 32'(exp_out), "R8 rd_data after scan");
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    exp_out = '0;
    #1;
    check(32'(rd_data), 32'd0, "R1 rd_data at reset");
    check(32'(scan_out), 32'd0, "R1 scan_out at reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2: fill memory with a per-address pattern and read it back.
    for (int a = 0; a < DEPTH; a++) write_word(AW'(a), DW'(a * 37 + 5));
    read_all("R2 normal read");
    read_word(AW'(3), "R2 normal read");
    // R3/R6/R9: unload longer than one image, ending mid-word, user ports toggled.
    scan_run(1'b0, L + DW + 3, 4, 1'b1, "R3 R6 unload stream");
    read_all("R6 R9 memory unchanged after unload");
    read_word(AW'(5), "R2 normal read");
    // R4: load one full image.
    scan_run(1'b1, L, 1, 1'b0, "R3 load-pass unload bits");
    read_all("R4 loaded memory image");
    // R5: two images, second half of stream echoes first half of input.
    read_word(AW'(6), "R2 normal read");
    scan_run(1'b1, 2 * L, 2, 1'b0, "R5 fifo echo");
    read_all("R5 memory after double load");
    // R10: aborted load inside the first word.
    read_word(AW'(1), "R2 normal read");
    scan_run(1'b1, 3, 3, 1'b0, "R10 short load stream");
    check(32'(rd_data), 32'(exp_mem[1]), "R10 rd_data preserved");
    read_all("R10 memory preserved");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule